// File: doc/BRIEF.md
# Memory-Card Command Issue and Response Capture

This block is the command front end of a memory-card host controller. Software programs a 32-bit command argument in two 16-bit halves over a small register bus and then writes a command word. The block holds the decoded command toward the card side until the card side returns a response. It then stores that response in eight 16-bit response registers and sets the matching completion and error flags in a status register.

The card side receives the command index, the argument, the data direction, the command type and the expected response kind. It answers with a single-cycle `rsp_valid`. A `rsp_present` flag tells whether any response came back, and a 128-bit response holds its first received byte in bits 127:120.

The block extracts card-status errors and the operating-conditions busy flag according to the response kind. An interrupt line follows the status bits, masked by an enable register. Bit-level line signalling and CRC checking are done elsewhere.

Top module: `sdcmd_front`

## Requirements
- R1: A write to word 0 (command) while idle, unless it is an init request, raises `cmd_req` on the next cycle. The command word is decoded as index = bits 5:0, direction = bit 15, type = bits 13:12 and response kind = bits 10:8. `cmd_req` and the decoded fields hold until `rsp_valid`, and `cmd_req` is low in the cycle after it.
- R2: A write to word 1 replaces only bits 15:0 of `cmd_arg`. A write to word 2 replaces only bits 31:16.
- R3: Launching a command clears all eight response registers (words 8 to 15).
- R4: A command word with bit 7 set and index 0 is an init request. It sets status bit 0 and raises no request.
- R5: A returned response is split into big-endian 16-bit pairs. Response register k (word 8+k) holds `rsp_data[16k+15:16k]`, so the first pair received lands in register 7.
- R6: If the response kind is not 0 and `rsp_present` is low, status bits 7 and 0 are set. Response kind 0 completes with status bit 0 only.
- R7: For response kind 1, status bit 14 is set if `rsp_data[127:96]` has any of bits 31:26, 24:19 or 16 set.
- R8: For response kind 6, status bit 14 is set if any of bits 15:13 of `rsp_data[111:96]` is set.
- R9: For response kind 3, status bit 12 is set when `rsp_data[127]` is clear (card busy).
- R10: A completion with a response present sets status bits 0 and 2.
- R11: Writing word 3 (status) clears each status bit written as 1.
- R12: `irq` is high one cycle after any bit of the status register ANDed with the 15-bit enable register (word 4) is set, and low one cycle after none is.
- R13: A command word written while `cmd_req` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| cmd_req | output | 1 | Command outstanding toward the card side |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_dir | output | 1 | Data direction |
| cmd_type | output | 2 | Command type |
| cmd_rsp_kind | output | 3 | Expected response kind |
| rsp_valid | input | 1 | Response handshake from the card side |
| rsp_present | input | 1 | A response was received |
| rsp_data | input | 128 | Response bytes, first byte in bits 127:120 |
| irq | output | 1 | Interrupt |

## Verification
A wrong status flag shows on the status read on the cycle right after `rsp_valid`. The same flag reaches `irq` one cycle later once its enable bit is set. A stuck or early-released request is visible on `cmd_req` in the cycle after the handshake. A stale or misordered response register shows up as soon as words 8 to 15 are read, both after completion and while the command is still outstanding.

// File: rtl/sdcmd_front.sv
module sdcmd_front #(
  parameter int          AW          = 4,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          cmd_req,
  output logic [5:0]    cmd_index,
  output logic [31:0]   cmd_arg,
  output logic          cmd_dir,
  output logic [1:0]    cmd_type,
  output logic [2:0]    cmd_rsp_kind,
  input  logic          rsp_valid,
  input  logic          rsp_present,
  input  logic [127:0]  rsp_data,
  output logic          irq
);
  localparam logic [AW-1:0] A_CMD = AW'(0);
  localparam logic [AW-1:0] A_ALO = AW'(1);
  localparam logic [AW-1:0] A_AHI = AW'(2);
  localparam logic [AW-1:0] A_STA = AW'(3);
  localparam logic [AW-1:0] A_IEN = AW'(4);
  localparam logic [2:0] K_NONE = 3'd0, K_R1 = 3'd1, K_OCR = 3'd3, K_R6 = 3'd6;

  logic [15:0]  cmd_q, arg_lo, arg_hi;
  logic [14:0]  stat, ien, st_set, st_clr;
  logic [127:0] rsp_q;
  logic         busy, irq_q;

  wire wr_cmd  = bus_we && bus_addr == A_CMD && !busy;
  wire is_init = bus_wdata[7] && bus_wdata[5:0] == 6'd0;
  wire launch  = wr_cmd && !is_init;
  wire init_ok = wr_cmd && is_init;
  wire done    = busy && rsp_valid;

  assign cmd_req      = busy;
  assign cmd_index    = cmd_q[5:0];
  assign cmd_dir      = cmd_q[15];
  assign cmd_type     = cmd_q[13:12];
  assign cmd_rsp_kind = cmd_q[10:8];
  assign cmd_arg      = {arg_hi, arg_lo};
  assign irq          = irq_q;

  always_comb begin
    st_set = '0;
    if (init_ok) st_set[0] = 1'b1;
    if (done) begin
      st_set[0] = 1'b1;
      if (cmd_rsp_kind != K_NONE) begin
        if (!rsp_present) st_set[7] = 1'b1;
        else begin
          st_set[2] = 1'b1;
          if (cmd_rsp_kind == K_R1 && |(rsp_data[127:96] & R1_ERR_MASK)) st_set[14] = 1'b1;
          if (cmd_rsp_kind == K_R6 && |(rsp_data[111:96] & R6_ERR_MASK)) st_set[14] = 1'b1;
          if (cmd_rsp_kind == K_OCR && !rsp_data[127]) st_set[12] = 1'b1;
        end
      end
    end
    st_clr = (bus_we && bus_addr == A_STA) ? bus_wdata[14:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      arg_lo <= '0;
      arg_hi <= '0;
      stat   <= '0;
      ien    <= '0;
      rsp_q  <= '0;
      busy   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_ALO) arg_lo <= bus_wdata;
      if (bus_we && bus_addr == A_AHI) arg_hi <= bus_wdata;
      if (bus_we && bus_addr == A_IEN) ien <= bus_wdata[14:0];
      if (launch) begin
        cmd_q <= bus_wdata;
        rsp_q <= '0;
        busy  <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
        if (rsp_present && cmd_rsp_kind != K_NONE) rsp_q <= rsp_data;
      end
      stat  <= (stat & ~st_clr) | st_set;
      irq_q <= |(stat & ien);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1]) bus_rdata = rsp_q[16*bus_addr[2:0] +: 16];
    else begin
      case (bus_addr)
        A_CMD:   bus_rdata = cmd_q;
        A_ALO:   bus_rdata = arg_lo;
        A_AHI:   bus_rdata = arg_hi;
        A_STA:   bus_rdata = {1'b0, stat};
        A_IEN:   bus_rdata = {1'b0, ien};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_front_chk.sv
module sdcmd_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        cmd_req,
  input logic [5:0]  cmd_index,
  input logic        rsp_valid,
  input logic        irq,
  input logic [14:0] stat,
  input logic [14:0] ien
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !rsp_valid |=> cmd_req && $stable(cmd_index));
  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && rsp_valid |=> !cmd_req);
  p_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_req && bus_we && bus_addr == 4'd0 && bus_wdata[7] && bus_wdata[5:0] == 6'd0
    |=> !cmd_req && stat[0]);
  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 4'd3 && !cmd_req |=> (stat & $past(bus_wdata[14:0])) == 15'd0);
  p_irq_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
    |(stat & ien) |=> irq);
  p_irq_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & ien)) |=> !irq);
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && bus_we && bus_addr == 4'd0 |=> $stable(cmd_index));
endmodule

bind sdcmd_front sdcmd_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cmd_req(cmd_req), .cmd_index(cmd_index),
  .rsp_valid(rsp_valid), .irq(irq), .stat(stat), .ien(ien)
);

// File: tb/sdcmd_front_tb.sv
`timescale 1ns/1ps
module sdcmd_front_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic [15:0]  bus_rdata;
  logic         cmd_req, cmd_dir, irq;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic [1:0]   cmd_type;
  logic [2:0]   cmd_rsp_kind;
  logic         rsp_valid = 1'b0, rsp_present = 1'b0;
  logic [127:0] rsp_data = '0;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  sdcmd_front dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung (act=%0d cycles exp<100000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {16'd0, bus_rdata}, {16'd0, exp});
  endtask

  task automatic respond(logic present, logic [127:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_present = present; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic clear_status();
    wr(4'd3, 16'h7FFF);
  endtask

  task automatic t_reset();
    chk("reset cmd_req", {31'd0, cmd_req}, 0);
    chk("reset irq", {31'd0, irq}, 0);
    rd_chk("reset status", 4'd3, 16'h0000);
    rd_chk("reset rsp7", 4'd15, 16'h0000);
  endtask

  task automatic t_args();
    wr(4'd1, 16'h1234);
    wr(4'd2, 16'hABCD);
    chk("R2 both halves", cmd_arg, 32'hABCD1234);
    wr(4'd1, 16'h5678);
    chk("R2 low only", cmd_arg, 32'hABCD5678);
    wr(4'd2, 16'h0F0F);
    chk("R2 high only", cmd_arg, 32'h0F0F5678);
  endtask

  task automatic t_r1_ok();
    wr(4'd0, 16'hA111);
    chk("R1 req", {31'd0, cmd_req}, 1);
    chk("R1 index", {26'd0, cmd_index}, 17);
    chk("R1 dir", {31'd0, cmd_dir}, 1);
    chk("R1 type", {30'd0, cmd_type}, 2);
    chk("R1 kind", {29'd0, cmd_rsp_kind}, 1);
    wr(4'd0, 16'h0005);
    chk("R13 busy write ignored", {26'd0, cmd_index}, 17);
    chk("R13 still req", {31'd0, cmd_req}, 1);
    respond(1'b1, 128'h00000900_11223344_55667788_99AABBCC);
    chk("R1 release", {31'd0, cmd_req}, 0);
    rd_chk("R10 R7 status clean", 4'd3, 16'h0005);
    rd_chk("R5 rsp7", 4'd15, 16'h0000);
    rd_chk("R5 rsp6", 4'd14, 16'h0900);
    rd_chk("R5 rsp3", 4'd11, 16'h5566);
    rd_chk("R5 rsp0", 4'd8, 16'hBBCC);
  endtask

  task automatic t_w1c();
    wr(4'd3, 16'h0001);
    rd_chk("R11 clear bit0", 4'd3, 16'h0004);
    wr(4'd3, 16'h0004);
    rd_chk("R11 clear bit2", 4'd3, 16'h0000);
  endtask

  task automatic t_rsp_clear();
    wr(4'd0, 16'h0202);
    rd_chk("R3 rsp6 cleared", 4'd14, 16'h0000);
    rd_chk("R3 rsp0 cleared", 4'd8, 16'h0000);
    respond(1'b1, {8{16'h0102}});
    rd_chk("R5 r2 capture", 4'd12, 16'h0102);
    clear_status();
  endtask

  task automatic t_r1_err();
    wr(4'd0, 16'h010D);
    respond(1'b1, {32'h8000_0000, 96'd0});
    rd_chk("R7 error bit31", 4'd3, 16'h4005);
    clear_status();
    wr(4'd0, 16'h010D);
    respond(1'b1, {32'h0001_0000, 96'd0});
    rd_chk("R7 error bit16", 4'd3, 16'h4005);
    clear_status();
    wr(4'd0, 16'h010D);
    respond(1'b1, {32'h0206_0000, 96'd0});
    rd_chk("R7 non-error bits", 4'd3, 16'h0005);
    clear_status();
  endtask

  task automatic t_r6();
    wr(4'd0, 16'h0603);
    respond(1'b1, {32'h1234_2000, 96'd0});
    rd_chk("R8 error bit13", 4'd3, 16'h4005);
    clear_status();
    wr(4'd0, 16'h0603);
    respond(1'b1, {32'hFFFF_1F00, 96'd0});
    rd_chk("R8 clean", 4'd3, 16'h0005);
    clear_status();
  endtask

  task automatic t_ocr();
    wr(4'd0, 16'h0301);
    respond(1'b1, {32'h00FF_8000, 96'd0});
    rd_chk("R9 busy", 4'd3, 16'h1005);
    clear_status();
    wr(4'd0, 16'h0301);
    respond(1'b1, {32'h80FF_8000, 96'd0});
    rd_chk("R9 ready", 4'd3, 16'h0005);
    clear_status();
  endtask

  task automatic t_timeout();
    wr(4'd0, 16'h0108);
    respond(1'b0, '0);
    rd_chk("R6 timeout", 4'd3, 16'h0081);
    clear_status();
    wr(4'd0, 16'h0000);
    chk("R6 kind0 req", {31'd0, cmd_req}, 1);
    respond(1'b0, '0);
    rd_chk("R6 kind0 done", 4'd3, 16'h0001);
    clear_status();
  endtask

  task automatic t_init();
    wr(4'd0, 16'h0080);
    chk("R4 no req", {31'd0, cmd_req}, 0);
    rd_chk("R4 status", 4'd3, 16'h0001);
    @(negedge clk);
    chk("R4 no req later", {31'd0, cmd_req}, 0);
  endtask

  task automatic t_irq();
    wr(4'd4, 16'h0001);
    chk("R12 irq lag", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R12 irq set", {31'd0, irq}, 1);
    wr(4'd3, 16'h0001);
    chk("R12 irq held one cycle", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R12 irq dropped", {31'd0, irq}, 0);
    wr(4'd0, 16'h0080);
    wr(4'd4, 16'h0004);
    @(negedge clk);
    chk("R12 masked", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_args();
    t_r1_ok();
    t_w1c();
    t_rsp_clear();
    t_r1_err();
    t_r6();
    t_ocr();
    t_timeout();
    t_init();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule